// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Controller

This block sits between the interrupt flags of a small microcontroller's peripherals and its CPU core. It accepts nine request lines: two external pins, three timers, the serial port, SPI, a keyboard port and a counter array. It presents exactly one of them to the core as a request flag, a vector index and a priority level. Each source is gated by its own enable bit, and a global enable bit gates all of them. Two configuration bits give each source one of four priority levels. One bit comes from a "priority-high" vector and one from a "priority-low" vector.

The core answers a request with an acknowledge pulse. It ends a handler with a return-from-interrupt pulse. The block keeps one in-service bit per level, so a handler can only be interrupted by a strictly higher level. Ties within a level go to a fixed polling order. The serial port's receive and transmit flags share one vector. The timer 2 overflow and external flags also share one vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_req is 0 and in_svc is 0000.
- R2: A source whose src_en bit is 0 is never presented, whatever its request does.
- R3: While glb_en is 0, no new request is presented, whatever src_en holds.
- R4: A source's level is {pri_hi[i], pri_lo[i]}. Value 3 is the highest level and 0 the lowest. Among eligible sources, the highest level wins.
- R5: Within one level, the lowest bit index wins. Bit i of src_req, src_en, pri_hi and pri_lo is vector i, in this order: 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2, 6 counter array, 7 keyboard, 8 SPI.
- R6: aux_req[0] (serial transmit) requests vector 4. aux_req[1] (timer 2 external flag) requests vector 5. Each uses the enable and priority bits of that vector.
- R7: A request is presented only if its level is strictly above the highest level set in in_svc. Equal or lower levels wait.
- R8: An ack while irq_req is 1 sets in_svc[irq_lvl] and drops irq_req on the next cycle.
- R9: A reti pulse clears the highest set bit of in_svc.
- R10: irq_req rises two clock edges after a qualifying request is driven. Once raised, irq_req, irq_vec and irq_lvl hold until ack, even if a higher request appears.
- R11: While irq_req is 1, irq_vec is below 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 9 | Request flags, one per vector |
| aux_req | input | 2 | Shared flags: [0] serial transmit, [1] timer 2 external |
| src_en | input | 9 | Per-source enables |
| glb_en | input | 1 | Global enable |
| pri_hi | input | 9 | High bit of each source's level |
| pri_lo | input | 9 | Low bit of each source's level |
| ack | input | 1 | Core accepts the presented request |
| reti | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 4 | Vector index of the presented request |
| irq_lvl | output | 2 | Level of the presented request |
| in_svc | output | 4 | In-service bit per level |

## Verification
Several properties are checked on every cycle:
- the presented vector stays frozen until acknowledged;
- it is always in range;
- it was enabled both globally and individually;
- it sits strictly above the in-service level;
- ack and reti push and pop exactly one in-service bit.

The choice of winner across levels and polling order can only be shown by the bench, which compares against an arithmetic model. So can the shared vectors and the step-by-step nesting scenario.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int NUM_SRC = 9;
    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;
    localparam int VEC_W   = $clog2(NUM_SRC);
    localparam int AUX_N   = 2;
    localparam int SER_IDX = 4;
    localparam int T2_IDX  = 5;
    localparam int AUX_SER = 0;
    localparam int AUX_T2  = 1;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] req;
        logic               pend;
        vec_t               vec;
        lvl_t               lvl;
    } ctl_t;

    function automatic lvl_t top_of(input logic [NUM_LVL-1:0] v);
        lvl_t r;
        r = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (v[i]) r = lvl_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_level_map.sv
module irq_level_map import irq_prio_pkg::*; (
    input  logic [NUM_SRC-1:0]            req,
    input  logic [NUM_SRC-1:0]            en,
    input  logic                          glb,
    input  logic [NUM_SRC-1:0]            hi,
    input  logic [NUM_SRC-1:0]            lo,
    output logic [NUM_SRC-1:0]            elig,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign elig[g] = req[g] & en[g] & glb;
        assign lvl[g]  = {hi[g], lo[g]};
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_prio_pkg::*; (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            elig,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    input  logic                          svc_any,
    input  lvl_t                          svc_top,
    output logic                          found,
    output vec_t                          win_idx,
    output lvl_t                          win_lvl
);
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        // ascending scan with strict compare keeps the lowest index on ties
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!svc_any || lvl[i] > svc_top) &&
                (!found || lvl[i] > win_lvl)) begin
                found   = 1'b1;
                win_idx = vec_t'(i);
                win_lvl = lvl[i];
            end
        end
    end

    // R2: a chosen winner was eligible (enabled, globally enabled, requesting)
    p_win_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> elig[win_idx]);
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track import irq_prio_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  lvl_t               set_lvl,
    input  logic               clr,
    output logic [NUM_LVL-1:0] svc,
    output logic               svc_any,
    output lvl_t               svc_top
);
    logic [NUM_LVL-1:0] svc_d, svc_q;

    always_comb begin
        svc_d = svc_q;
        if (clr && svc_q != '0) svc_d[top_of(svc_q)] = 1'b0;
        if (set_en) svc_d[set_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_d;
    end

    assign svc     = svc_q;
    assign svc_any = |svc_q;
    assign svc_top = top_of(svc_q);

    // R8: acknowledge marks its level as in service
    p_push_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> svc_q[$past(set_lvl)]);

    // R9: a return pops exactly one level
    p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_en && svc_q != '0) |=>
            $countones(svc_q) == $countones($past(svc_q)) - 1);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl import irq_prio_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [AUX_N-1:0]   aux_req,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               glb_en,
    input  logic [NUM_SRC-1:0] pri_hi,
    input  logic [NUM_SRC-1:0] pri_lo,
    input  logic               ack,
    input  logic               reti,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [LVL_W-1:0]   irq_lvl,
    output logic [NUM_LVL-1:0] in_svc
);
    ctl_t ctl_d, ctl_q;

    logic [NUM_SRC-1:0]            elig;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_map;
    logic                          found;
    vec_t                          win_idx;
    lvl_t                          win_lvl;
    logic                          svc_any;
    lvl_t                          svc_top;
    logic                          take;

    irq_level_map u_map (
        .req  (ctl_q.req),
        .en   (src_en),
        .glb  (glb_en),
        .hi   (pri_hi),
        .lo   (pri_lo),
        .elig (elig),
        .lvl  (lvl_map)
    );

    irq_arbiter u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (elig),
        .lvl     (lvl_map),
        .svc_any (svc_any),
        .svc_top (svc_top),
        .found   (found),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    assign take = ack & ctl_q.pend;

    irq_svc_track u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (take),
        .set_lvl (ctl_q.lvl),
        .clr     (reti),
        .svc     (in_svc),
        .svc_any (svc_any),
        .svc_top (svc_top)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.req = src_req;
        ctl_d.req[SER_IDX] = src_req[SER_IDX] | aux_req[AUX_SER];
        ctl_d.req[T2_IDX]  = src_req[T2_IDX]  | aux_req[AUX_T2];
        if (ctl_q.pend) begin
            if (ack) ctl_d.pend = 1'b0;
        end else if (found) begin
            ctl_d.pend = 1'b1;
            ctl_d.vec  = win_idx;
            ctl_d.lvl  = win_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq_req = ctl_q.pend;
    assign irq_vec = ctl_q.vec;
    assign irq_lvl = ctl_q.lvl;

    // R10: presented request frozen until acknowledged
    p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !ack) |=> (irq_req && $stable(irq_vec) && $stable(irq_lvl)));

    // R11: vector index in range
    p_vec_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_vec < VEC_W'(NUM_SRC));

    // R3: a new request only rises while globally enabled
    p_glb_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(glb_en));

    // R7: a new request lies strictly above the in-service level
    p_above_svc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req) && $past(in_svc) != '0) |-> irq_lvl > top_of($past(in_svc)));

    // R8: acknowledge withdraws the request
    p_ack_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack) |=> !irq_req);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] src_req = '0;
    logic [1:0] aux_req = '0;
    logic [8:0] src_en = '0;
    logic       glb_en = 1'b0;
    logic [8:0] pri_hi = '0;
    logic [8:0] pri_lo = '0;
    logic       ack = 1'b0;
    logic       reti = 1'b0;
    logic       irq_req;
    logic [3:0] irq_vec;
    logic [1:0] irq_lvl;
    logic [3:0] in_svc;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .aux_req(aux_req),
        .src_en(src_en), .glb_en(glb_en), .pri_hi(pri_hi), .pri_lo(pri_lo),
        .ack(ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_lvl(irq_lvl), .in_svc(in_svc)
    );

    // model from the requirements: returns {found, vec[3:0], lvl[1:0]}
    function automatic logic [6:0] model(input logic [8:0] rq, input logic [1:0] ax,
                                         input logic [8:0] en, input logic g,
                                         input logic [8:0] hi, input logic [8:0] lo,
                                         input logic [3:0] svc);
        logic [8:0] r;
        logic f;
        int bv, bl, top;
        r = rq;
        r[4] = r[4] | ax[0];
        r[5] = r[5] | ax[1];
        f = 1'b0; bv = 0; bl = 0; top = -1;
        for (int k = 0; k < 4; k++) if (svc[k]) top = k;
        for (int i = 0; i < 9; i++) begin
            int l;
            l = 2 * int'(hi[i]) + int'(lo[i]);
            if (r[i] && en[i] && g && l > top && (!f || l > bl)) begin
                f = 1'b1; bv = i; bl = l;
            end
        end
        return {f, 4'(bv), 2'(bl)};
    endfunction

    task automatic chk(input string tag, input logic [6:0] exp);
        n_run++;
        if (irq_req !== exp[6] || (exp[6] && (irq_vec !== exp[5:2] || irq_lvl !== exp[1:0]))) begin
            n_fail++;
            $display("FAIL %s: got req=%0b vec=%0d lvl=%0d, expected req=%0b vec=%0d lvl=%0d",
                     tag, irq_req, irq_vec, irq_lvl, exp[6], exp[5:2], exp[1:0]);
        end
    endtask

    task automatic chk_svc(input string tag, input logic [3:0] exp);
        n_run++;
        if (in_svc !== exp) begin
            n_fail++;
            $display("FAIL %s: in_svc got %b expected %b", tag, in_svc, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ack_clear();
        ack = 1'b1; src_req = '0; aux_req = '0;
        cyc(1);
        ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1;
        cyc(1);
        reti = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [6:0] e;
        cyc(3);
        chk("R1 reset request", 7'b0);
        chk_svc("R1 reset in-service", 4'b0000);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 idle after reset", 7'b0);

        // R2: disabled source ignored, enabled one taken
        glb_en = 1; src_en = 9'h1FF & ~9'h001; src_req = 9'h001;
        cyc(2); chk("R2 disabled source", 7'b0);
        src_en = 9'h1FF; src_req = 9'h003; pri_hi = 9'h000; pri_lo = 9'h000;
        src_en[0] = 1'b0;
        cyc(2); chk("R2 next enabled wins", {1'b1, 4'd1, 2'd0});
        pulse_ack_clear(); pulse_reti();

        // R3: global disable masks all
        src_en = 9'h1FF; glb_en = 0; src_req = 9'h1FF;
        cyc(3); chk("R3 global off", 7'b0);
        glb_en = 1;
        cyc(2); chk("R3 global on", {1'b1, 4'd0, 2'd0});
        pulse_ack_clear(); pulse_reti();

        // R6: shared vectors
        aux_req = 2'b01; cyc(2); chk("R6 serial transmit", {1'b1, 4'd4, 2'd0});
        pulse_ack_clear(); pulse_reti();
        aux_req = 2'b10; cyc(2); chk("R6 timer2 external", {1'b1, 4'd5, 2'd0});
        pulse_ack_clear(); pulse_reti();

        // R10: latency and hold
        pri_hi = '0; pri_lo = '0; pri_hi[0] = 1; pri_lo[0] = 1;
        src_req = 9'h002; cyc(1);
        chk("R10 not yet after one edge", 7'b0);
        cyc(1); chk("R10 raised after two edges", {1'b1, 4'd1, 2'd0});
        src_req = 9'h003; cyc(3);
        chk("R10 held against higher request", {1'b1, 4'd1, 2'd0});
        pulse_ack_clear();
        chk("R8 ack drops request", 7'b0);
        chk_svc("R8 ack sets level 0", 4'b0001);
        pulse_reti(); chk_svc("R9 pop to empty", 4'b0000);

        // R7/R8/R9 nesting scenario
        pri_hi = '0; pri_lo = '0;
        pri_lo[0] = 1; pri_lo[8] = 1; pri_hi[7] = 1; pri_lo[7] = 1;
        src_req = 9'h001; cyc(2);
        chk("R7 first level-1 request", {1'b1, 4'd0, 2'd1});
        ack = 1; cyc(1); ack = 0;
        chk_svc("R8 level 1 in service", 4'b0010);
        src_req = 9'h101; cyc(3);
        chk("R7 equal level waits", 7'b0);
        src_req = 9'h181; cyc(2);
        chk("R7 higher level preempts", {1'b1, 4'd7, 2'd3});
        ack = 1; src_req = 9'h101; cyc(1); ack = 0;
        chk_svc("R8 nested levels", 4'b1010);
        cyc(2); chk("R7 nothing above level 3", 7'b0);
        pulse_reti(); chk_svc("R9 pops highest", 4'b0010);
        cyc(2); chk("R7 level-1 still waits", 7'b0);
        pulse_reti(); chk_svc("R9 pops last", 4'b0000);
        cyc(1); chk("R5 tie on level 1 lowest index", {1'b1, 4'd0, 2'd1});
        pulse_ack_clear(); pulse_reti();
        chk_svc("R9 empty after cleanup", 4'b0000);

        // R4/R5/R11 sweep against the model, in-service empty
        for (int t = 0; t < 600; t++) begin
            src_req = 9'($urandom); aux_req = 2'($urandom);
            src_en  = 9'($urandom) | 9'($urandom);
            glb_en  = (($urandom % 4) != 0);
            pri_hi  = 9'($urandom); pri_lo = 9'($urandom);
            if (t < 64) begin
                // every level pair on sources 0 and 8 with both requesting
                src_req = 9'h101; aux_req = 0; src_en = 9'h1FF; glb_en = 1;
                pri_hi = {t[3], 7'b0, t[1]}; pri_lo = {t[2], 7'b0, t[0]};
            end
            e = model(src_req, aux_req, src_en, glb_en, pri_hi, pri_lo, 4'b0);
            cyc(2);
            chk("R4 R5 R11 sweep", e);
            if (e[6]) begin
                pulse_ack_clear();
                pulse_reti();
            end else begin
                src_req = '0; aux_req = '0;
                cyc(2);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule